// File: doc/BRIEF.md
# Phase-Aware DRAM Request Priority Selector

This block chooses, every cycle, which one of a small pool of pending DRAM requests the command issuer should service next. Each pool slot reports whether it holds a request, whether that request is a read or a write, whether its row is already open (so its next command is a column access) or still needs an activate or precharge, an external priority hint, the thread that issued it, and whether DRAM timing currently allows its next command. The selector keeps its own per-slot age counter and a per-slot promotion flag. From these, the scheduling mode supplied by the controller and per-thread queued-read counts, it gives each slot a rank and grants the best one.

Reads gain priority in three ways. They age into priority and later into a timed-out class. Reads from a thread with very few queued reads get a boost. A strobe that marks the arrival of a read from a compute-phase thread promotes every queued read of that thread at once. The rank order depends on whether the controller is in its read-drain mode or in one of its three write-oriented modes (write drain, pre-refresh, refresh). Request storage, address comparison and DRAM timing checks are outside this block; timing legality arrives on the issuable input.

Top module: `dram_prio_selector`

## Requirements
- R1: A slot competes only when its valid and issuable inputs are both high; when no slot qualifies, `gnt_vld` is low.
- R2: With `mode` = 0 (read drain) the ranks from best to worst are: timed-out read; low-parallelism read; priority row-hit read; priority activate/precharge read; row-hit write; normal row-hit read; normal activate/precharge read; priority activate/precharge write; normal activate/precharge write.
- R3: With `mode` = 1, 2 or 3 the ranks from best to worst are: row-hit write; timed-out read; low-parallelism read; priority row-hit read; normal row-hit read; priority activate/precharge read; priority activate/precharge write; normal activate/precharge write.
- R4: With `mode` other than 0, a read that is not row-hit, not priority, not low-parallelism and not timed out is never granted.
- R5: Among qualifying slots of equal rank, the one with the largest age wins; equal ages go to the lowest slot index.
- R6: A read is low-parallelism when the queued-read count of its thread (field `tid` of `thr_rdcnt`, `CNT_W` bits, thread 0 in the low bits) is below `MLP_TH`.
- R7: A slot's age is the number of clock edges it has been valid since it last became valid; a read with age at least `PRIO_CYC` is priority.
- R8: A read with age at least `TIMEOUT_CYC` is timed out.
- R9: A clock edge with `promo_stb` high makes every valid read whose thread equals `promo_tid` priority until that slot goes invalid; other threads and writes are unaffected.
- R10: Ages saturate at `TIMEOUT_CYC` and never wrap.
- R11: While `rst_n` is low, ages and promotion flags are held at zero.
- R12: A write is priority only through its `req_prio` hint; a read is priority through `req_prio`, aging or promotion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Scheduling mode: 0 read drain, 1 write drain, 2 pre-refresh, 3 refresh |
| req_vld | input | N_ENT | Slot holds a request |
| req_wr | input | N_ENT | Request is a write |
| req_rowhit | input | N_ENT | Row is open; next command is a column access |
| req_prio | input | N_ENT | External priority hint |
| req_iss | input | N_ENT | DRAM timing allows the slot's next command |
| req_tid | input | N_ENT*TID_W | Thread of each slot, slot 0 in the low bits |
| thr_rdcnt | input | N_THR*CNT_W | Queued-read count per thread, thread 0 in the low bits |
| promo_stb | input | 1 | Compute-phase read arrival for thread `promo_tid` |
| promo_tid | input | TID_W | Thread to promote |
| gnt_vld | output | 1 | A slot was granted |
| gnt_idx | output | IDX_W | Index of the granted slot |

## Verification
The bench builds the selector with four slots, two threads, a 4-bit count width, an aging threshold of 6 cycles, a timeout of 12 cycles and a low-parallelism threshold of 2. These small thresholds put aging into priority, the timeout class and the wrap point of a 4-bit age counter within a few tens of cycles, so saturation is visible at the grant. With four slots every rank of both orderings can be set against another in a single table row, and ties between equal ages are reached whenever slots become valid together.

// File: rtl/dps_pkg.sv
// Shared types and the rank table for the DRAM request priority selector.
// Assumes ranks fit in four bits; a smaller rank is a better rank.
package dps_pkg;

    typedef enum logic [1:0] {
        MODE_READ    = 2'd0,
        MODE_WRITE   = 2'd1,
        MODE_PREREF  = 2'd2,
        MODE_REFRESH = 2'd3
    } sched_mode_e;

    typedef logic [3:0] level_t;

    localparam level_t LVL_NONE = 4'd15;

    // Maps one request's attributes to its rank under the current mode.
    function automatic level_t rank_of(
        input logic rd_mode,
        input logic wr,
        input logic rh,
        input logic pr,
        input logic tmo,
        input logic lmlp
    );
        if (wr) begin
            if (rh)      return rd_mode ? 4'd4 : 4'd0;
            else if (pr) return rd_mode ? 4'd7 : 4'd6;
            else         return rd_mode ? 4'd8 : 4'd7;
        end
        if (tmo)  return rd_mode ? 4'd0 : 4'd1;
        if (lmlp) return rd_mode ? 4'd1 : 4'd2;
        if (rh) begin
            if (pr) return rd_mode ? 4'd2 : 4'd3;
            else    return rd_mode ? 4'd5 : 4'd4;
        end
        if (pr) return rd_mode ? 4'd3 : 4'd5;
        return rd_mode ? 4'd6 : LVL_NONE;
    endfunction

endpackage

// File: rtl/dps_entry_tracker.sv
// Per-slot age counter and compute-phase promotion flag.
// Assumes the slot's valid input drops for at least one edge between requests;
// age and flag clear whenever the slot is empty or reset is low.
module dps_entry_tracker #(
    parameter int PRIO_CYC    = 100000,
    parameter int TIMEOUT_CYC = 1000000,
    parameter int TID_W       = 2,
    localparam int AGE_W      = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld,
    input  logic             wr,
    input  logic [TID_W-1:0] tid,
    input  logic             promo_stb,
    input  logic [TID_W-1:0] promo_tid,
    output logic [AGE_W-1:0] age,
    output logic             aged,
    output logic             timed,
    output logic             promoted
);
    localparam logic [AGE_W-1:0] AGE_MAX  = AGE_W'(TIMEOUT_CYC);
    localparam logic [AGE_W-1:0] PRIO_AGE = AGE_W'(PRIO_CYC);

    logic [AGE_W-1:0] age_q;
    logic             promo_q;

    // Saturating age count while the slot is occupied.
    always_ff @(posedge clk) begin
        if (!rst_n || !vld)      age_q <= '0;
        else if (age_q != AGE_MAX) age_q <= age_q + 1'b1;
    end

    // Sticky promotion for reads of the strobed thread.
    always_ff @(posedge clk) begin
        if (!rst_n || !vld)                           promo_q <= 1'b0;
        else if (promo_stb && !wr && tid == promo_tid) promo_q <= 1'b1;
    end

    assign age      = age_q;
    assign aged     = (age_q >= PRIO_AGE);
    assign timed    = (age_q >= AGE_MAX);
    assign promoted = promo_q;

    a_r7_age_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && age_q != AGE_MAX) |=> (!vld || age_q == $past(age_q) + 1'b1));
    a_r10_age_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && age_q == AGE_MAX) |=> (!vld || age_q == AGE_MAX));
    a_r9_promotion_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (promo_stb && vld && !wr && tid == promo_tid) |=> (!vld || promo_q));

endmodule

// File: rtl/dps_rank_encoder.sv
// Computes one slot's rank from its request attributes and tracker state.
// Assumes the thread count has already been selected for this slot's thread.
module dps_rank_encoder
    import dps_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int MLP_TH = 2
) (
    input  logic             rd_mode,
    input  logic             vld,
    input  logic             iss,
    input  logic             wr,
    input  logic             rowhit,
    input  logic             hint,
    input  logic             aged,
    input  logic             timed,
    input  logic             promoted,
    input  logic [CNT_W-1:0] thr_cnt,
    output level_t           level
);
    localparam logic [CNT_W-1:0] MLP_LIM = CNT_W'(MLP_TH);

    logic pr, tmo, lmlp;

    // Read-only boosts; writes keep only their hint.
    always_comb begin
        pr    = hint | (!wr & (aged | promoted));
        tmo   = !wr & timed;
        lmlp  = !wr & (thr_cnt < MLP_LIM);
        level = (vld && iss) ? rank_of(rd_mode, wr, rowhit, pr, tmo, lmlp) : LVL_NONE;
    end

endmodule

// File: rtl/dps_winner_pick.sv
// Picks the best rank, then the largest age, then the lowest index.
// Assumes LVL_NONE marks a slot that does not compete.
module dps_winner_pick
    import dps_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int AGE_W = 20,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [N_ENT*4-1:0]     lvl_flat,
    input  logic [N_ENT*AGE_W-1:0] age_flat,
    output logic                   win_vld,
    output logic [IDX_W-1:0]       win_idx
);
    level_t           best_lvl;
    logic [AGE_W-1:0] best_age;

    // Linear scan; strict compares keep the lowest index on a full tie.
    always_comb begin
        best_lvl = LVL_NONE;
        best_age = '0;
        win_idx  = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (lvl_flat[i*4 +: 4] != LVL_NONE &&
                (lvl_flat[i*4 +: 4] < best_lvl ||
                 (lvl_flat[i*4 +: 4] == best_lvl && age_flat[i*AGE_W +: AGE_W] > best_age))) begin
                best_lvl = lvl_flat[i*4 +: 4];
                best_age = age_flat[i*AGE_W +: AGE_W];
                win_idx  = IDX_W'(i);
            end
        end
        win_vld = (best_lvl != LVL_NONE);
    end

endmodule

// File: rtl/dram_prio_selector.sv
// Top: ranks every pool slot under the current mode and grants one per cycle.
// Assumes req_iss already reflects DRAM timing legality of each slot's command.
module dram_prio_selector
    import dps_pkg::*;
#(
    parameter int N_ENT       = 8,
    parameter int N_THR       = 4,
    parameter int CNT_W       = 8,
    parameter int PRIO_CYC    = 100000,
    parameter int TIMEOUT_CYC = 1000000,
    parameter int MLP_TH      = 2,
    localparam int TID_W      = (N_THR > 1) ? $clog2(N_THR) : 1,
    localparam int IDX_W      = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int AGE_W      = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             mode,
    input  logic [N_ENT-1:0]       req_vld,
    input  logic [N_ENT-1:0]       req_wr,
    input  logic [N_ENT-1:0]       req_rowhit,
    input  logic [N_ENT-1:0]       req_prio,
    input  logic [N_ENT-1:0]       req_iss,
    input  logic [N_ENT*TID_W-1:0] req_tid,
    input  logic [N_THR*CNT_W-1:0] thr_rdcnt,
    input  logic                   promo_stb,
    input  logic [TID_W-1:0]       promo_tid,
    output logic                   gnt_vld,
    output logic [IDX_W-1:0]       gnt_idx
);
    logic                   rd_mode;
    logic [N_ENT*4-1:0]     lvl_flat;
    logic [N_ENT*AGE_W-1:0] age_flat;

    assign rd_mode = (mode == MODE_READ);

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        logic [TID_W-1:0] tid;
        logic [CNT_W-1:0] cnt;
        logic [AGE_W-1:0] age;
        logic             aged, timed, promoted;
        level_t           level;

        assign tid = req_tid[g*TID_W +: TID_W];
        assign cnt = thr_rdcnt[int'(tid)*CNT_W +: CNT_W];

        dps_entry_tracker #(
            .PRIO_CYC    (PRIO_CYC),
            .TIMEOUT_CYC (TIMEOUT_CYC),
            .TID_W       (TID_W)
        ) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .vld       (req_vld[g]),
            .wr        (req_wr[g]),
            .tid       (tid),
            .promo_stb (promo_stb),
            .promo_tid (promo_tid),
            .age       (age),
            .aged      (aged),
            .timed     (timed),
            .promoted  (promoted)
        );

        dps_rank_encoder #(
            .CNT_W  (CNT_W),
            .MLP_TH (MLP_TH)
        ) u_rank (
            .rd_mode  (rd_mode),
            .vld      (req_vld[g]),
            .iss      (req_iss[g]),
            .wr       (req_wr[g]),
            .rowhit   (req_rowhit[g]),
            .hint     (req_prio[g]),
            .aged     (aged),
            .timed    (timed),
            .promoted (promoted),
            .thr_cnt  (cnt),
            .level    (level)
        );

        assign lvl_flat[g*4 +: 4]         = level;
        assign age_flat[g*AGE_W +: AGE_W] = age;
    end

    dps_winner_pick #(
        .N_ENT (N_ENT),
        .AGE_W (AGE_W)
    ) u_pick (
        .lvl_flat (lvl_flat),
        .age_flat (age_flat),
        .win_vld  (gnt_vld),
        .win_idx  (gnt_idx)
    );

    a_r1_grant_is_legal: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> (req_vld[gnt_idx] && req_iss[gnt_idx]));
    a_r1_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_vld & req_iss) == '0) |-> !gnt_vld);
    a_r3_row_hit_write_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_mode && gnt_vld && (req_vld & req_iss & req_wr & req_rowhit) != '0)
            |-> (req_wr[gnt_idx] && req_rowhit[gnt_idx]));

endmodule

// File: tb/dram_prio_selector_bench.sv
module dram_prio_selector_bench;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [3:0] req_vld = '0, req_wr = '0, req_rowhit = '0, req_prio = '0, req_iss = '0;
    logic [3:0] req_tid = '0;
    logic [7:0] thr_rdcnt = '0;
    logic       promo_stb = 1'b0;
    logic       promo_tid = 1'b0;
    logic       gnt_vld;
    logic [1:0] gnt_idx;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    dram_prio_selector #(
        .N_ENT(N), .N_THR(2), .CNT_W(4),
        .PRIO_CYC(6), .TIMEOUT_CYC(12), .MLP_TH(2)
    ) u_dram_prio_selector (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .req_vld(req_vld), .req_wr(req_wr), .req_rowhit(req_rowhit),
        .req_prio(req_prio), .req_iss(req_iss), .req_tid(req_tid),
        .thr_rdcnt(thr_rdcnt), .promo_stb(promo_stb), .promo_tid(promo_tid),
        .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
    );

    // {mode, vld, wr, rowhit, iss, prio, tid, cnt1, cnt0, exp_vld, exp_idx}
    localparam int NV = 14;
    localparam logic [36:0] VEC [NV] = '{
        {2'd0, 4'b0011, 4'b0001, 4'b0011, 4'b1111, 4'b0000, 4'b0000, 4'd5, 4'd5, 1'b1, 2'd0}, // R2 row-hit write over normal row-hit read
        {2'd0, 4'b0011, 4'b0010, 4'b0010, 4'b1111, 4'b0001, 4'b0000, 4'd5, 4'd5, 1'b1, 2'd0}, // R2 prio act read over row-hit write
        {2'd1, 4'b0011, 4'b0010, 4'b0010, 4'b1111, 4'b0001, 4'b0000, 4'd5, 4'd5, 1'b1, 2'd1}, // R3 row-hit write first
        {2'd1, 4'b0100, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'd5, 4'd5, 1'b0, 2'd0}, // R4 normal act read blocked
        {2'd0, 4'b0100, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'd5, 4'd5, 1'b1, 2'd2}, // R4 allowed in read mode
        {2'd0, 4'b0011, 4'b0000, 4'b0001, 4'b1111, 4'b0001, 4'b0010, 4'd1, 4'd5, 1'b1, 2'd1}, // R6 count 1 is low
        {2'd0, 4'b0011, 4'b0000, 4'b0001, 4'b1111, 4'b0001, 4'b0010, 4'd2, 4'd5, 1'b1, 2'd0}, // R6 count 2 not low
        {2'd0, 4'b0011, 4'b0001, 4'b0011, 4'b1110, 4'b0000, 4'b0000, 4'd5, 4'd5, 1'b1, 2'd1}, // R1 not issuable excluded
        {2'd1, 4'b1010, 4'b1010, 4'b1010, 4'b1111, 4'b0000, 4'b0000, 4'd5, 4'd5, 1'b1, 2'd1}, // R5 tie to lowest index
        {2'd1, 4'b1011, 4'b0011, 4'b0000, 4'b1111, 4'b1001, 4'b0000, 4'd5, 4'd5, 1'b1, 2'd3}, // R3 prio act read over writes
        {2'd0, 4'b0111, 4'b0011, 4'b0000, 4'b1111, 4'b0001, 4'b0000, 4'd5, 4'd5, 1'b1, 2'd2}, // R2 normal act read over writes
        {2'd2, 4'b0011, 4'b0010, 4'b0001, 4'b1111, 4'b0010, 4'b0000, 4'd5, 4'd5, 1'b1, 2'd0}, // R12 write hint below row-hit read
        {2'd3, 4'b0000, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'd5, 4'd5, 1'b0, 2'd0}, // R1 empty pool
        {2'd3, 4'b0011, 4'b0000, 4'b0001, 4'b1111, 4'b0001, 4'b0010, 4'd0, 4'd5, 1'b1, 2'd1}  // R3 low-MLP over prio row-hit
    };

    task automatic check(input string req, input int act_v, input int act_i,
                         input int exp_v, input int exp_i);
        checks++;
        if (act_v != exp_v || (exp_v != 0 && act_i != exp_i)) begin
            errors++;
            $display("FAIL %s: got vld=%0d idx=%0d, expected vld=%0d idx=%0d",
                     req, act_v, act_i, exp_v, exp_i);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_pool();
        req_vld = '0; req_wr = '0; req_rowhit = '0; req_prio = '0;
        req_iss = 4'b1111; req_tid = '0; thr_rdcnt = {4'd5, 4'd5};
        edges(1);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: got vld=%0d idx=%0d, expected finish", gnt_vld, gnt_idx);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R11: a normal act read held under reset must not age into priority.
        mode = 2'd1; req_iss = 4'b1111; thr_rdcnt = {4'd5, 4'd5}; req_vld = 4'b0001;
        edges(10);
        rst_n = 1'b1;
        #1;
        check("R11 reset holds age", gnt_vld, gnt_idx, 0, 0);
        clear_pool();

        // Table walk: every slot enters together, so ages are equal.
        for (int v = 0; v < NV; v++) begin
            clear_pool();
            mode = VEC[v][36:35]; req_vld = VEC[v][34:31]; req_wr = VEC[v][30:27];
            req_rowhit = VEC[v][26:23]; req_iss = VEC[v][22:19]; req_prio = VEC[v][18:15];
            req_tid = VEC[v][14:11]; thr_rdcnt = {VEC[v][10:7], VEC[v][6:3]};
            #1;
            check($sformatf("R2/R3 table row %0d", v), gnt_vld, gnt_idx,
                  VEC[v][2], VEC[v][1:0]);
        end

        // R5: older slot beats lower index at equal rank.
        clear_pool();
        mode = 2'd1; req_wr = 4'b0101; req_rowhit = 4'b0101; req_vld = 4'b0100;
        edges(3);
        req_vld = 4'b0101;
        edges(1);
        check("R5 oldest wins", gnt_vld, gnt_idx, 1, 2);

        // R7: normal act read outside read mode becomes grantable at age 6.
        clear_pool();
        mode = 2'd1; req_vld = 4'b0001;
        edges(5);
        check("R7 age 5 not priority", gnt_vld, gnt_idx, 0, 0);
        edges(1);
        check("R7 age 6 priority", gnt_vld, gnt_idx, 1, 0);

        // R8/R10: slot0 normal act read, slot1 row-hit write, slot2 low-MLP read later.
        clear_pool();
        mode = 2'd0; req_wr = 4'b0010; req_rowhit = 4'b0010; req_tid = 4'b0100;
        thr_rdcnt = {4'd0, 4'd5}; req_vld = 4'b0011;
        edges(3);
        req_vld = 4'b0111;
        edges(8);
        check("R8 age 11 not timed out", gnt_vld, gnt_idx, 1, 2);
        edges(1);
        check("R8 age 12 timed out", gnt_vld, gnt_idx, 1, 0);
        req_vld = 4'b0011;
        edges(20);
        check("R10 age saturates", gnt_vld, gnt_idx, 1, 0);

        // R9: promote thread 0; slot1 older than slot0; slot2 is thread 1.
        clear_pool();
        mode = 2'd1; req_tid = 4'b0100; req_vld = 4'b0110;
        edges(1);
        req_vld = 4'b0111;
        edges(1);
        check("R9 before promotion", gnt_vld, gnt_idx, 0, 0);
        promo_stb = 1'b1; promo_tid = 1'b0;
        edges(1);
        promo_stb = 1'b0;
        check("R9 thread promoted", gnt_vld, gnt_idx, 1, 1);
        req_vld = 4'b0100;
        edges(1);
        check("R9 other thread untouched", gnt_vld, gnt_idx, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule